// File: doc/BRIEF.md
# UART Interrupt Identification

This block gathers the interrupt causes of a 16550-style serial port and reports the most urgent one. It produces a 4-bit identity code that software reads to find the cause, and it drives a single interrupt line. It also brings out one flag per source after masking.

The block keeps a sticky pending flag for each event-driven cause: line errors, modem-line changes and the busy-write condition. It clears each flag on the register read that belongs to that cause. The received-data cause is judged directly from the receive FIFO level against the trigger level, or against a single character when the FIFOs are off.

Two rules need their own state:

- **Character timeout.** The timeout counter counts character-time ticks whenever the receive FIFO holds data and nothing has been pushed into or popped from it.
- **Transmit empty.** The transmit-empty cause is taken either from the holding register or, in threshold mode, from the transmit FIFO level against a threshold.

The surrounding UART supplies the strobes for the register accesses. The serializer, the FIFOs and baud generation sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with no source pending, `id_o` is 4'b0001 and `irq_o` is low.
- R2: Codes and order, most urgent first:
  - line status: 4'b0110
  - received data: 4'b0100, which ranks above character timeout (4'b1100) at the same level
  - transmit empty: 4'b0010
  - modem status: 4'b0000
  - busy detect: 4'b0111
- R3: Any bit of `ls_err_i` sets the line-status cause in the next cycle. A pulse on `ls_rd_i` with no new error clears it in the next cycle.
- R4: Received data is shown in the same cycle in two cases:
  - with `fifo_en_i` high, while `rx_level_i >= rx_trig_i`;
  - with `fifo_en_i` low, while `rx_level_i != 0`.
  It goes away as soon as that condition ends.
- R5: With the FIFO enabled and `rx_level_i` nonzero, the character timeout is raised by the fourth `char_tick_i` since the last push or pop, in the cycle after that tick. `rx_push_i` or `rx_pop_i` restarts the count. `rx_buf_rd_i` clears the timeout.
- R6: Transmit empty is set one cycle after its condition becomes true. The condition is `tx_hold_empty_i` in normal mode, or `tx_level_i <= tx_thresh_i` when `tx_thr_mode_i` is high. It is cleared by any of these:
  - `tx_hold_wr_i`;
  - the condition going false;
  - `id_rd_i` while `id_o` is 4'b0010.
  A read of the identity register while another source is shown leaves transmit empty pending.
- R7: Any bit of `msr_chg_i` sets the modem-status cause. `ms_rd_i` clears it.
- R8: `line_ctl_wr_i` while `busy_i` is high sets busy detect. The same write with `busy_i` low does not. `stat_rd_i` clears busy detect.
- R9: `src_en_i` masks causes:
  - bit 0 masks received data and timeout;
  - bit 1 masks transmit empty;
  - bit 2 masks line status;
  - bit 3 masks modem status.
  A masked line or modem cause stays latched and appears when it is unmasked. `pend_o` carries one bit per cause after masking: bit 0 line, bit 1 received data, bit 2 timeout, bit 3 transmit empty, bit 4 modem, bit 5 busy.
- R10: `irq_o` is high whenever `id_o` differs from 4'b0001, including for the modem code 4'b0000.
- R11: A new line, modem or busy event arriving in the same cycle as its clearing read leaves the cause set. For the timeout, a receive-buffer read in the same cycle as the firing tick wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en_i | input | 4 | Source enables (rx/timeout, tx empty, line, modem) |
| ls_err_i | input | 4 | Overrun, parity, framing, break event pulses |
| ls_rd_i | input | 1 | Line status register read strobe |
| fifo_en_i | input | 1 | FIFOs enabled |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive trigger level |
| rx_push_i | input | 1 | Character entered the receive FIFO |
| rx_pop_i | input | 1 | Character left the receive FIFO |
| rx_buf_rd_i | input | 1 | Receive buffer read strobe |
| char_tick_i | input | 1 | One pulse per character time |
| tx_hold_empty_i | input | 1 | Transmit holding register empty |
| tx_thr_mode_i | input | 1 | Transmit threshold mode on |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| tx_thresh_i | input | LVL_W | Transmit threshold |
| tx_hold_wr_i | input | 1 | Transmit holding register write strobe |
| id_rd_i | input | 1 | Identity register read strobe |
| msr_chg_i | input | 4 | CTS, DSR, RI, DCD change pulses |
| ms_rd_i | input | 1 | Modem status register read strobe |
| line_ctl_wr_i | input | 1 | Line control register write strobe |
| busy_i | input | 1 | UART busy flag |
| stat_rd_i | input | 1 | UART status register read strobe |
| id_o | output | 4 | Interrupt identity code |
| irq_o | output | 1 | Interrupt request |
| pend_o | output | 6 | Masked pending flag per source |

## Verification
The hardest situation to reach is the character timeout. It needs a non-empty FIFO and exactly four character ticks with no push or pop among them, and a single stray pop must visibly restart the count. The stimulus counts out three ticks, pops to restart, counts three more to show nothing fired, and then delivers the fourth. It also lands a buffer read on the very cycle of a firing tick. The transmit-empty rule about reads of the identity register is reached by holding a line error pending over a pending transmit-empty cause, so that the read happens while another code is shown.

// File: rtl/uart_irq_pkg.sv
// Package: identity codes and source indices shared by the interrupt
// identification block, its sub-blocks and its checker.
package uart_irq_pkg;

    localparam int NSRC = 6;

    // Source positions in the pending vector.
    localparam int S_LINE  = 0;
    localparam int S_RXD   = 1;
    localparam int S_TOUT  = 2;
    localparam int S_TXE   = 3;
    localparam int S_MODEM = 4;
    localparam int S_BUSY  = 5;

    // Identity codes read by software.
    typedef enum logic [3:0] {
        ID_MODEM = 4'b0000,
        ID_NONE  = 4'b0001,
        ID_TXE   = 4'b0010,
        ID_RXD   = 4'b0100,
        ID_LINE  = 4'b0110,
        ID_BUSY  = 4'b0111,
        ID_TOUT  = 4'b1100
    } irq_id_e;

endpackage

// File: rtl/uart_irq_sticky.sv
// Module: bank of W sticky flags.
// Each flag sets on its event and clears on its read strobe. An event in the
// same cycle as the read wins, so no event is lost.
// Assumes set and clear are single-cycle strobes synchronous to clk.
module uart_irq_sticky #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);

    for (genvar g = 0; g < W; g++) begin : g_flag
        // Per-flag set/clear register, set has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_o[g] <= 1'b0;
            else if (set_i[g])
                flag_o[g] <= 1'b1;
            else if (clr_i[g])
                flag_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/uart_irq_rx_timeout.sv
// Module: receive character-timeout detector.
// Counts character-time ticks while the FIFO is enabled and holds data.
// Any push or pop restarts the count. The TO_CHARS-th tick raises the
// timeout, which holds until the receive buffer is read; a read in the
// firing cycle wins. Assumes char_tick_i is a one-cycle pulse.
module uart_irq_rx_timeout #(
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic             rx_buf_rd_i,
    input  logic             char_tick_i,
    output logic             tout_o
);

    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TO_CHARS - 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(TO_CHARS);

    logic [CW-1:0] cnt_q;
    logic          armed;
    logic          activity;
    logic          fire;

    // Decide whether counting is allowed and whether this tick completes it.
    always_comb begin
        armed    = fifo_en_i && (rx_level_i != '0);
        activity = rx_push_i || rx_pop_i;
        fire     = armed && !activity && char_tick_i && (cnt_q == CNT_LAST);
    end

    // Tick counter, restarted by FIFO traffic, saturating once fired.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (activity || !armed)
            cnt_q <= '0;
        else if (char_tick_i && cnt_q != CNT_DONE)
            cnt_q <= cnt_q + 1'b1;
    end

    // Timeout flag, read of the buffer has priority over firing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tout_o <= 1'b0;
        else if (rx_buf_rd_i)
            tout_o <= 1'b0;
        else if (fire)
            tout_o <= 1'b1;
    end

endmodule

// File: rtl/uart_irq_tx_empty.sv
// Module: transmit-empty cause.
// The condition is the holding register empty flag, or the FIFO level at or
// below the threshold in threshold mode. The cause is set when the condition
// (or the enable) newly becomes true. It is cleared by a holding-register
// write, by an identity read that reported it, or by the condition ending.
module uart_irq_tx_empty #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             hold_empty_i,
    input  logic             thr_mode_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] thresh_i,
    input  logic             hold_wr_i,
    input  logic             id_rd_hit_i,
    output logic             txe_o
);

    logic cond;
    logic cond_q;
    logic en_q;

    // Select the empty condition for the active mode.
    always_comb begin
        cond = thr_mode_i ? (level_i <= thresh_i) : hold_empty_i;
    end

    // Remember last condition and enable to detect new arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            cond_q <= cond;
            en_q   <= en_i;
        end
    end

    // Pending flag, any clear beats a new set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            txe_o <= 1'b0;
        else if (!cond || hold_wr_i || id_rd_hit_i)
            txe_o <= 1'b0;
        else if (en_i && !(cond_q && en_q))
            txe_o <= 1'b1;
    end

endmodule

// File: rtl/uart_irq_prio.sv
// Module: fixed-priority encoder from masked pending flags to identity code.
// Order: line, received data, timeout, transmit empty, modem, busy.
// Purely combinational.
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic [NSRC-1:0] pend_i,
    output irq_id_e         id_o
);

    // Pick the most urgent pending source.
    always_comb begin
        if (pend_i[S_LINE])
            id_o = ID_LINE;
        else if (pend_i[S_RXD])
            id_o = ID_RXD;
        else if (pend_i[S_TOUT])
            id_o = ID_TOUT;
        else if (pend_i[S_TXE])
            id_o = ID_TXE;
        else if (pend_i[S_MODEM])
            id_o = ID_MODEM;
        else if (pend_i[S_BUSY])
            id_o = ID_BUSY;
        else
            id_o = ID_NONE;
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Module: UART interrupt identification, top level.
// Combines sticky event causes, the receive-level and timeout causes and the
// transmit-empty cause, masks them with the source enables and encodes the
// most urgent one. Assumes all strobes are one-cycle pulses in the clk domain.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       src_en_i,
    input  logic [3:0]       ls_err_i,
    input  logic             ls_rd_i,
    input  logic             fifo_en_i,
    input  logic [LVL_W-1:0] rx_level_i,
    input  logic [LVL_W-1:0] rx_trig_i,
    input  logic             rx_push_i,
    input  logic             rx_pop_i,
    input  logic             rx_buf_rd_i,
    input  logic             char_tick_i,
    input  logic             tx_hold_empty_i,
    input  logic             tx_thr_mode_i,
    input  logic [LVL_W-1:0] tx_level_i,
    input  logic [LVL_W-1:0] tx_thresh_i,
    input  logic             tx_hold_wr_i,
    input  logic             id_rd_i,
    input  logic [3:0]       msr_chg_i,
    input  logic             ms_rd_i,
    input  logic             line_ctl_wr_i,
    input  logic             busy_i,
    input  logic             stat_rd_i,
    output logic [3:0]       id_o,
    output logic             irq_o,
    output logic [5:0]       pend_o
);

    localparam int EN_RX    = 0;
    localparam int EN_TX    = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    logic [2:0] stk_set;
    logic [2:0] stk_clr;
    logic [2:0] stk_flag;
    logic       rxd_raw;
    logic       tout_raw;
    logic       txe_raw;
    logic       id_rd_hit;
    irq_id_e    id_enc;

    // Event inputs for the sticky bank: line, modem, busy.
    always_comb begin
        stk_set = {line_ctl_wr_i && busy_i, |msr_chg_i, |ls_err_i};
        stk_clr = {stat_rd_i, ms_rd_i, ls_rd_i};
    end

    uart_irq_sticky #(.W(3)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (stk_set),
        .clr_i  (stk_clr),
        .flag_o (stk_flag)
    );

    // Received-data level rule for FIFO and non-FIFO operation.
    always_comb begin
        rxd_raw = fifo_en_i ? (rx_level_i >= rx_trig_i) : (rx_level_i != '0);
    end

    uart_irq_rx_timeout #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) u_tout (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_en_i   (fifo_en_i),
        .rx_level_i  (rx_level_i),
        .rx_push_i   (rx_push_i),
        .rx_pop_i    (rx_pop_i),
        .rx_buf_rd_i (rx_buf_rd_i),
        .char_tick_i (char_tick_i),
        .tout_o      (tout_raw)
    );

    // An identity read counts only if transmit empty is what it reports.
    always_comb begin
        id_rd_hit = id_rd_i && (id_enc == ID_TXE);
    end

    uart_irq_tx_empty #(.LVL_W(LVL_W)) u_txe (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (src_en_i[EN_TX]),
        .hold_empty_i (tx_hold_empty_i),
        .thr_mode_i   (tx_thr_mode_i),
        .level_i      (tx_level_i),
        .thresh_i     (tx_thresh_i),
        .hold_wr_i    (tx_hold_wr_i),
        .id_rd_hit_i  (id_rd_hit),
        .txe_o        (txe_raw)
    );

    // Apply the source enables; busy detect is always enabled.
    always_comb begin
        pend_o          = '0;
        pend_o[S_LINE]  = stk_flag[0] && src_en_i[EN_LINE];
        pend_o[S_RXD]   = rxd_raw     && src_en_i[EN_RX];
        pend_o[S_TOUT]  = tout_raw    && src_en_i[EN_RX];
        pend_o[S_TXE]   = txe_raw     && src_en_i[EN_TX];
        pend_o[S_MODEM] = stk_flag[1] && src_en_i[EN_MODEM];
        pend_o[S_BUSY]  = stk_flag[2];
    end

    uart_irq_prio u_prio (
        .pend_i (pend_o),
        .id_o   (id_enc)
    );

    // Drive the identity code and the request line.
    always_comb begin
        id_o  = id_enc;
        irq_o = (id_enc != ID_NONE);
    end

endmodule

// File: rtl/uart_irq_ident_chk.sv
// Module: property checker for uart_irq_ident, attached with bind.
// Observes ports only; holds no state of its own.
module uart_irq_ident_chk
    import uart_irq_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       src_en_i,
    input logic [3:0]       ls_err_i,
    input logic             ls_rd_i,
    input logic             fifo_en_i,
    input logic [LVL_W-1:0] rx_level_i,
    input logic [LVL_W-1:0] rx_trig_i,
    input logic             rx_buf_rd_i,
    input logic             id_rd_i,
    input logic [3:0]       msr_chg_i,
    input logic             ms_rd_i,
    input logic             line_ctl_wr_i,
    input logic             busy_i,
    input logic [3:0]       id_o,
    input logic             irq_o,
    input logic [5:0]       pend_o
);

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o == 6'd0) |-> (id_o == ID_NONE && !irq_o));

    p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o[S_LINE] |-> (id_o == ID_LINE));

    p_line_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_rd_i && ls_err_i == 4'd0) |=> !pend_o[S_LINE]);

    p_rxd_shown_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en_i && src_en_i[0] && rx_level_i >= rx_trig_i && !pend_o[S_LINE])
            |-> (id_o == ID_RXD));

    p_tout_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_buf_rd_i |=> !pend_o[S_TOUT]);

    p_txe_id_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd_i && id_o == ID_TXE) |=> !pend_o[S_TXE]);

    p_modem_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_rd_i && msr_chg_i == 4'd0) |=> !pend_o[S_MODEM]);

    p_busy_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_ctl_wr_i && busy_i) |=> pend_o[S_BUSY]);

    p_pend_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o != 6'd0) |-> irq_o);

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.LVL_W(LVL_W)) u_chk (.*);

// File: tb/uart_irq_ident_tb.sv
// Bench: scoreboard for uart_irq_ident. Driver tasks push expected identity
// codes; a monitor at the falling edge pops and compares them.
module uart_irq_ident_tb;

    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    src_en = 4'hF;
    logic [3:0]    ls_err = '0;
    logic          ls_rd = 1'b0;
    logic          fifo_en = 1'b1;
    logic [LW-1:0] rx_level = '0;
    logic [LW-1:0] rx_trig = 5'd4;
    logic          rx_push = 1'b0;
    logic          rx_pop = 1'b0;
    logic          rx_buf_rd = 1'b0;
    logic          char_tick = 1'b0;
    logic          tx_hold_empty = 1'b0;
    logic          tx_thr_mode = 1'b0;
    logic [LW-1:0] tx_level = '0;
    logic [LW-1:0] tx_thresh = '0;
    logic          tx_hold_wr = 1'b0;
    logic          id_rd = 1'b0;
    logic [3:0]    msr_chg = '0;
    logic          ms_rd = 1'b0;
    logic          line_ctl_wr = 1'b0;
    logic          busy = 1'b0;
    logic          stat_rd = 1'b0;
    logic [3:0]    id_o;
    logic          irq_o;
    logic [5:0]    pend_o;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [3:0] id;
        logic       irq;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    uart_irq_ident #(.LVL_W(LW), .TO_CHARS(4)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .src_en_i        (src_en),
        .ls_err_i        (ls_err),
        .ls_rd_i         (ls_rd),
        .fifo_en_i       (fifo_en),
        .rx_level_i      (rx_level),
        .rx_trig_i       (rx_trig),
        .rx_push_i       (rx_push),
        .rx_pop_i        (rx_pop),
        .rx_buf_rd_i     (rx_buf_rd),
        .char_tick_i     (char_tick),
        .tx_hold_empty_i (tx_hold_empty),
        .tx_thr_mode_i   (tx_thr_mode),
        .tx_level_i      (tx_level),
        .tx_thresh_i     (tx_thresh),
        .tx_hold_wr_i    (tx_hold_wr),
        .id_rd_i         (id_rd),
        .msr_chg_i       (msr_chg),
        .ms_rd_i         (ms_rd),
        .line_ctl_wr_i   (line_ctl_wr),
        .busy_i          (busy),
        .stat_rd_i       (stat_rd),
        .id_o            (id_o),
        .irq_o           (irq_o),
        .pend_o          (pend_o)
    );

    // Monitor: compare outputs with the oldest expected item.
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (id_o !== e.id || irq_o !== e.irq) begin
                n_bad++;
                $display("FAIL %s: id=%b irq=%b expected id=%b irq=%b",
                         e.tag, id_o, irq_o, e.id, e.irq);
            end
        end
    end

    // Advance one cycle; inputs change 1 ns after the edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Push the expected code for this cycle; irq follows R10.
    task automatic chk(input logic [3:0] id, input string tag);
        sb_q.push_back('{id, (id != 4'b0001), tag});
        tick();
    endtask

    // Direct check of the masked pending vector.
    task automatic chk_pend(input logic [5:0] exp, input string tag);
        @(negedge clk);
        n_chk++;
        if (pend_o !== exp) begin
            n_bad++;
            $display("FAIL %s: pend=%b expected pend=%b", tag, pend_o, exp);
        end
        tick();
    endtask

    task automatic char_time();
        char_tick = 1'b1; tick(); char_tick = 1'b0; tick();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8 * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL R1 watchdog: finished=0 expected=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(4'b0001, "R1 reset idle");

        // R3: line errors, cleared by line status read
        ls_err = 4'b0010; tick(); ls_err = '0;
        chk(4'b0110, "R3 parity error");
        ls_rd = 1'b1; tick(); ls_rd = 1'b0;
        chk(4'b0001, "R3 cleared by read");
        ls_err = 4'b1000; tick(); ls_err = '0;
        chk(4'b0110, "R3 break");
        ls_rd = 1'b1; tick(); ls_rd = 1'b0;

        // R4: received data level rules
        rx_level = 5'd4;
        chk(4'b0100, "R4 at trigger");
        rx_level = 5'd3;
        chk(4'b0001, "R4 below trigger");
        fifo_en = 1'b0; rx_level = 5'd1;
        chk(4'b0100, "R4 single char no fifo");
        rx_level = 5'd0;
        chk(4'b0001, "R4 buffer emptied");
        fifo_en = 1'b1;

        // R2: line status above received data
        rx_level = 5'd4; ls_err = 4'b0001; tick(); ls_err = '0;
        chk(4'b0110, "R2 line over rx data");
        ls_rd = 1'b1; tick(); ls_rd = 1'b0;
        chk(4'b0100, "R2 rx data next");
        rx_level = 5'd0;
        chk(4'b0001, "R2 idle again");

        // R5: character timeout
        rx_level = 5'd2; rx_push = 1'b1; tick(); rx_push = 1'b0;
        for (int i = 0; i < 3; i++) char_time();
        chk(4'b0001, "R5 three ticks only");
        rx_pop = 1'b1; rx_level = 5'd1; tick(); rx_pop = 1'b0;
        for (int i = 0; i < 3; i++) char_time();
        chk(4'b0001, "R5 restart after pop");
        char_tick = 1'b1; tick(); char_tick = 1'b0;
        chk(4'b1100, "R5 fourth tick");
        rx_level = 5'd4;
        chk(4'b0100, "R2 rx data over timeout");
        rx_level = 5'd1;
        chk(4'b1100, "R5 timeout still held");
        rx_buf_rd = 1'b1; rx_pop = 1'b1; rx_level = 5'd0; tick();
        rx_buf_rd = 1'b0; rx_pop = 1'b0;
        chk(4'b0001, "R5 cleared by buffer read");

        // R6: transmit empty, normal mode
        tx_hold_empty = 1'b1; tick();
        chk(4'b0010, "R6 holding empty");
        id_rd = 1'b1; tick(); id_rd = 1'b0;
        chk(4'b0001, "R6 identity read clears");
        chk(4'b0001, "R6 no re-raise while empty");
        tx_hold_empty = 1'b0; tick(); tx_hold_empty = 1'b1; tick();
        chk(4'b0010, "R6 raised again");
        ls_err = 4'b0001; tick(); ls_err = '0;
        chk(4'b0110, "R6 line shown above tx");
        id_rd = 1'b1; tick(); id_rd = 1'b0;
        ls_rd = 1'b1; tick(); ls_rd = 1'b0;
        chk(4'b0010, "R6 survives read when not reported");
        tx_hold_wr = 1'b1; tick(); tx_hold_wr = 1'b0;
        chk(4'b0001, "R6 holding write clears");
        tx_hold_empty = 1'b0; tick();

        // R6: threshold mode
        tx_thr_mode = 1'b1; tx_thresh = 5'd2; tx_level = 5'd5; tick();
        chk(4'b0001, "R6 above threshold");
        tx_level = 5'd2; tick();
        chk(4'b0010, "R6 at threshold");
        tx_level = 5'd3; tick();
        chk(4'b0001, "R6 rising above clears");
        tx_thr_mode = 1'b0; tx_level = '0; tick();

        // R7 and R10: modem change gives code 0000 with irq high
        msr_chg = 4'b0100; tick(); msr_chg = '0;
        chk(4'b0000, "R7 R10 modem change");
        ms_rd = 1'b1; tick(); ms_rd = 1'b0;
        chk(4'b0001, "R7 cleared by read");

        // R8: busy detect
        line_ctl_wr = 1'b1; tick(); line_ctl_wr = 1'b0;
        chk(4'b0001, "R8 write while idle");
        busy = 1'b1; line_ctl_wr = 1'b1; tick(); line_ctl_wr = 1'b0; busy = 1'b0;
        chk(4'b0111, "R8 write while busy");
        msr_chg = 4'b0001; tick(); msr_chg = '0;
        chk(4'b0000, "R2 modem over busy");
        chk_pend(6'b110000, "R9 pending vector modem and busy");
        ms_rd = 1'b1; tick(); ms_rd = 1'b0;
        chk(4'b0111, "R8 busy remains");
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
        chk(4'b0001, "R8 cleared by status read");

        // R9: masking
        src_en = 4'b0111; msr_chg = 4'b0001; tick(); msr_chg = '0;
        chk(4'b0001, "R9 modem masked");
        src_en = 4'hF;
        chk(4'b0000, "R9 latched modem appears");
        ms_rd = 1'b1; tick(); ms_rd = 1'b0;
        src_en = 4'b1110; rx_level = 5'd4;
        chk(4'b0001, "R9 rx data masked");
        rx_level = '0; src_en = 4'hF;

        // R11: simultaneous event and read
        ls_err = 4'b0100; ls_rd = 1'b1; tick(); ls_err = '0; ls_rd = 1'b0;
        chk(4'b0110, "R11 new error beats read");
        ls_rd = 1'b1; tick(); ls_rd = 1'b0;
        chk(4'b0001, "R11 line cleared");
        rx_level = 5'd1; rx_push = 1'b1; tick(); rx_push = 1'b0;
        for (int i = 0; i < 3; i++) char_time();
        char_tick = 1'b1; rx_buf_rd = 1'b1; tick();
        char_tick = 1'b0; rx_buf_rd = 1'b0;
        chk(4'b0001, "R11 read beats firing tick");
        rx_level = '0;

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule